// File: doc/BRIEF.md
# Time-Multiplexed MAC FIR Filter

This block is a single-channel finite impulse response filter built around one shared multiplier. Each accepted input sample starts a sweep in which a sequencer visits the taps one per clock. In each cycle it reads one stored sample and one coefficient from synchronous RAM, multiplies them, and adds the product into an accumulator. When the sweep drains, the accumulator is scaled by an arithmetic right shift and clamped to the output width. The result appears for one cycle with a valid strobe.

The sample history sits in a circular RAM. A new sample replaces the oldest entry. Coefficients sit in a second RAM that can be rewritten at run time through an address/data/enable port, so the impulse response can change without rebuilding the design.

An even-symmetry mode pairs the two samples that share a coefficient. A pre-adder sums them before the multiply, which halves the sweep length and the number of coefficients used.

The filter suits sample rates far below the clock. With `TAPS` taps, a new sample may be offered every `TAPS + 4` clocks in normal mode. In symmetric mode the minimum spacing is `TAPS/2 + 4` clocks.

Top module: `fir_tdm_mac`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_valid` is 0, `out_sample` is 0 and `ready` is 1.
- R2: With `sym_mode` low at acceptance, the result is `sat((sum over k = 0..TAPS-1 of c[k]*x[k]) >>> SHIFT)`. Here `c[k]` is the coefficient at write address k, `x[0]` is the sample just accepted, `x[k]` is the sample accepted k samples earlier, and all values are two's complement.
- R3: With `sym_mode` high at acceptance, the result is `sat((sum over k = 0..TAPS/2-1 of c[k]*(x[k] + x[TAPS-1-k])) >>> SHIFT)`. Coefficient addresses TAPS/2 and up are not read.
- R4: `out_valid` is high for exactly one cycle. It rises M+3 rising edges after the edge that accepted the sample, where M is TAPS in normal mode and TAPS/2 in symmetric mode. `out_sample` keeps its value between pulses.
- R5: `ready` drops on the edge that accepts a sample and returns on the edge that raises `out_valid`. While `ready` is low, `in_valid` and `cw_en` are ignored: no sample enters the history and no coefficient changes.
- R6: A write with `cw_en` high while `ready` is high stores `cw_data` at `cw_addr`. If a sample is accepted in the same cycle, the new coefficient already applies to that sample's result.
- R7: Results above 32767 give 32767 and results below -32768 give -32768 (16-bit output).
- R8: The history holds exactly the last TAPS accepted samples, and each accepted sample displaces the oldest one.
- R9: The accumulator starts from zero for every accepted sample, so no earlier sweep leaks into a result.
- R10: Each result is built from exactly M accumulate steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Offers `in_sample`; taken when `ready` is high |
| in_sample | input | DATA_W | Input sample, two's complement |
| sym_mode | input | 1 | Even-symmetry mode, sampled with the accepted sample |
| ready | output | 1 | Idle: a sample or coefficient write is taken this cycle |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | $clog2(TAPS) | Coefficient address (tap index) |
| cw_data | input | COEF_W | Coefficient value, two's complement |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_sample | output | DATA_W | Scaled, saturated filter result |

## Verification
A coefficient write and a sample acceptance can land in the same idle cycle. The bench drives `cw_en` and `in_valid` together on one falling edge and expects the result to already use the rewritten coefficient, as its reference model computes it.

The bench also forces overlap from the other side: during a sweep it presents both a new sample and a coefficient write while `ready` is low. It then checks that the current result and the next one both match a model that received neither.

// File: rtl/fir_tdm_pkg.sv
// Package: shared types for the time-multiplexed MAC FIR.
// Assumes: nothing beyond IEEE 1800-2017.
package fir_tdm_pkg;

    // Sequencer states: wait for a sample, step the taps, drain and publish.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SWEEP = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_t;

endpackage

// File: rtl/fir_hist_ram.sv
// Sample history RAM: one write port, two registered read ports.
// Each read returns the addressed word one cycle later. No reset on the array,
// so it maps onto block RAM. The second port supplies the mirror sample of a
// symmetric pair. Assumes no read targets the address written in the same cycle.
module fir_hist_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    // Store a new sample and register both read words.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata_a <= mem[raddr_a];
        rdata_b <= mem[raddr_b];
    end
endmodule

// File: rtl/fir_coef_ram.sv
// Coefficient RAM: one write port, one registered read port.
// Writes beyond DEPTH-1 are dropped, so depths that are not a power of two stay safe.
module fir_coef_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];

    // Accept in-range writes and register the read word.
    always_ff @(posedge clk) begin
        if (we && (waddr <= TOP_ADDR)) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/fir_seq_ctrl.sv
// Sweep sequencer. In idle it takes a sample, writes it at the history head
// and starts a sweep. Each sweep cycle issues one tap read. Pointer A walks
// back from the newest sample; pointer B walks forward from the oldest (used
// only in symmetric mode). The drain state waits for the datapath pipeline to
// empty, then fires the publish strobe and returns to idle.
// Assumes: TAPS even and >= 2.
module fir_seq_ctrl
    import fir_tdm_pkg::*;
#(
    parameter int TAPS = 8,
    localparam int AW  = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          sym_mode,
    input  logic          pipe_busy,
    output logic          ready,
    output logic          start,
    output logic          issue,
    output logic          publish,
    output logic          sym_q,
    output logic [AW-1:0] head,
    output logic [AW-1:0] ptr_a,
    output logic [AW-1:0] ptr_b,
    output logic [AW-1:0] tap
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(TAPS - 1);
    localparam logic [AW-1:0] HALF_LAST = AW'(TAPS / 2 - 1);

    seq_state_t    state;
    logic [AW-1:0] last_tap;

    // Circular increment.
    function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
        return (p == LAST_ADDR) ? '0 : p + 1'b1;
    endfunction

    // Circular decrement.
    function automatic logic [AW-1:0] step_dn(input logic [AW-1:0] p);
        return (p == '0) ? LAST_ADDR : p - 1'b1;
    endfunction

    // Decode handshake and strobes from the state.
    always_comb begin
        ready    = (state == SEQ_IDLE);
        start    = ready && in_valid;
        issue    = (state == SEQ_SWEEP);
        publish  = (state == SEQ_DRAIN) && !pipe_busy;
        last_tap = sym_q ? HALF_LAST : LAST_ADDR;
    end

    // Advance the state, the pointers and the tap index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            head  <= '0;
            ptr_a <= '0;
            ptr_b <= '0;
            tap   <= '0;
            sym_q <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: if (in_valid) begin
                    ptr_a <= head;
                    ptr_b <= step_up(head);
                    head  <= step_up(head);
                    tap   <= '0;
                    sym_q <= sym_mode;
                    state <= SEQ_SWEEP;
                end
                SEQ_SWEEP: begin
                    ptr_a <= step_dn(ptr_a);
                    ptr_b <= step_up(ptr_b);
                    tap   <= tap + 1'b1;
                    if (tap == last_tap) state <= SEQ_DRAIN;
                end
                SEQ_DRAIN: if (!pipe_busy) state <= SEQ_IDLE;
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fir_mac_dp.sv
// MAC datapath. The stage-1 flag marks cycles whose RAM words are valid
// (one cycle after a tap read is issued). A pre-adder then folds in the mirror
// sample when symmetric, and the product is registered. The stage-2 flag adds
// the registered product into the accumulator, so every tap is counted exactly
// once. The accumulator clears on sweep start; on publish the shifted,
// clamped result is registered with a one-cycle strobe.
module fir_mac_dp #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32,
    parameter int SHIFT  = 8,
    localparam int PRE_W  = DATA_W + 1,
    localparam int PROD_W = PRE_W + COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     issue,
    input  logic                     publish,
    input  logic                     sym,
    input  logic signed [DATA_W-1:0] samp_a,
    input  logic signed [DATA_W-1:0] samp_b,
    input  logic signed [COEF_W-1:0] coef,
    output logic                     pipe_busy,
    output logic                     acc_en,
    output logic                     out_valid,
    output logic        [DATA_W-1:0] out_sample
);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(-(1 <<< (DATA_W - 1)));

    logic                     rd_vld;
    logic signed [PRE_W-1:0]  pre_sum;
    logic signed [PROD_W-1:0] prod_full;
    logic signed [ACC_W-1:0]  prod_q;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  scaled;

    // Pre-add the mirror sample in symmetric mode, then multiply.
    always_comb begin
        pre_sum   = PRE_W'(samp_a) + (sym ? PRE_W'(samp_b) : '0);
        prod_full = pre_sum * coef;
        scaled    = acc >>> SHIFT;
        pipe_busy = rd_vld || acc_en;
    end

    // Carry the read-valid and accumulate-enable flags down the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
            acc_en <= 1'b0;
        end else begin
            rd_vld <= issue;
            acc_en <= rd_vld;
        end
    end

    // Register the product of the current tap.
    always_ff @(posedge clk) begin
        if (!rst_n)      prod_q <= '0;
        else if (rd_vld) prod_q <= ACC_W'(prod_full);
    end

    // Clear at sweep start, else add the registered product.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (acc_en)     acc <= acc + prod_q;
    end

    // Publish the scaled, clamped result with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= publish;
            if (publish) begin
                if (scaled > SAT_HI)      out_sample <= DATA_W'(SAT_HI);
                else if (scaled < SAT_LO) out_sample <= DATA_W'(SAT_LO);
                else                      out_sample <= DATA_W'(scaled);
            end
        end
    end
endmodule

// File: rtl/fir_tdm_mac.sv
// Top: time-multiplexed MAC FIR with one multiplier, RAM-held history and
// reloadable coefficients. Offer a new sample only after the previous result;
// samples and coefficient writes offered while ready is low are dropped.
// Assumes: TAPS even and >= 2; the accumulator is wide enough for the chosen
// coefficient and sample ranges (it wraps otherwise).
module fir_tdm_mac #(
    parameter int TAPS   = 8,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32,
    parameter int SHIFT  = 8,
    localparam int AW    = $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              sym_mode,
    output logic              ready,
    input  logic              cw_en,
    input  logic [AW-1:0]     cw_addr,
    input  logic [COEF_W-1:0] cw_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    logic              start, issue, publish, sym_q, pipe_busy, acc_en;
    logic [AW-1:0]     head, ptr_a, ptr_b, tap;
    logic [DATA_W-1:0] samp_a, samp_b;
    logic [COEF_W-1:0] coef;
    logic              coef_we;

    // Coefficient writes are taken only while idle.
    assign coef_we = cw_en && ready;

    fir_seq_ctrl #(.TAPS(TAPS)) seq_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_mode(sym_mode),
        .pipe_busy(pipe_busy), .ready(ready), .start(start), .issue(issue),
        .publish(publish), .sym_q(sym_q), .head(head), .ptr_a(ptr_a),
        .ptr_b(ptr_b), .tap(tap)
    );

    fir_hist_ram #(.DW(DATA_W), .DEPTH(TAPS)) hist_i (
        .clk(clk), .we(start), .waddr(head), .wdata(in_sample),
        .raddr_a(ptr_a), .raddr_b(ptr_b), .rdata_a(samp_a), .rdata_b(samp_b)
    );

    fir_coef_ram #(.DW(COEF_W), .DEPTH(TAPS)) coef_i (
        .clk(clk), .we(coef_we), .waddr(cw_addr), .wdata(cw_data),
        .raddr(tap), .rdata(coef)
    );

    fir_mac_dp #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .SHIFT(SHIFT)
    ) dp_i (
        .clk(clk), .rst_n(rst_n), .clear(start), .issue(issue),
        .publish(publish), .sym(sym_q), .samp_a(samp_a), .samp_b(samp_b),
        .coef(coef), .pipe_busy(pipe_busy), .acc_en(acc_en),
        .out_valid(out_valid), .out_sample(out_sample)
    );
endmodule

// File: rtl/fir_tdm_mac_chk.sv
// Checker for fir_tdm_mac: handshake, strobe shape and accumulate count.
// Bound into every instance of the top module.
module fir_tdm_mac_chk #(
    parameter int TAPS   = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              sym_mode,
    input logic              ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_sample,
    input logic              acc_en
);
    localparam int CW = $clog2(TAPS + 1) + 1;

    logic [CW-1:0] n_mac;
    logic [CW-1:0] n_want;

    // Count accumulate steps since the last accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_mac  <= '0;
            n_want <= '0;
        end else if (in_valid && ready) begin
            n_mac  <= '0;
            n_want <= sym_mode ? CW'(TAPS / 2) : CW'(TAPS);
        end else if (acc_en) begin
            n_mac <= n_mac + 1'b1;
        end
    end

    // R10
    mac_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (n_mac == n_want));

    // R4
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));

    // R5
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready) |=> !ready);

    // R5
    ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ready);
endmodule

bind fir_tdm_mac fir_tdm_mac_chk #(.TAPS(TAPS), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_mode(sym_mode),
    .ready(ready), .out_valid(out_valid), .out_sample(out_sample),
    .acc_en(acc_en)
);

// File: tb/fir_tdm_mac_tb_top.sv
// Bench for fir_tdm_mac: table-driven sample stream against a reference
// model, then directed tests for reset, busy intrusion, coincident writes
// and saturation.
module fir_tdm_mac_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS  = 8;
    localparam int SHIFT = 8;

    // {sym_mode, sample}
    localparam logic [16:0] VEC [12] = '{
        {1'b0,  16'sd100},  {1'b0, -16'sd250}, {1'b0,  16'sd1800},
        {1'b0, -16'sd1999}, {1'b0,  16'sd7},   {1'b1,  16'sd640},
        {1'b1, -16'sd1200}, {1'b1,  16'sd333}, {1'b0,  16'sd0},
        {1'b1,  16'sd2000}, {1'b0, -16'sd77},  {1'b1, -16'sd512}
    };
    localparam int INIT_C [TAPS] = '{120, -64, 300, 45, -200, 90, 33, -17};

    logic        clk = 1'b0;
    logic        rst_n, in_valid, sym_mode, cw_en;
    logic [15:0] in_sample, cw_data;
    logic [2:0]  cw_addr;
    logic        ready, out_valid;
    logic [15:0] out_sample;

    int n_total = 0;
    int n_bad   = 0;
    int hist_m [TAPS];
    int coef_m [TAPS];

    fir_tdm_mac #(.TAPS(TAPS), .SHIFT(SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .sym_mode(sym_mode), .ready(ready), .cw_en(cw_en), .cw_addr(cw_addr),
        .cw_data(cw_data), .out_valid(out_valid), .out_sample(out_sample)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Record one check and report it if it failed.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference result from the requirement formulas.
    function automatic int model(input bit sym);
        longint acc = 0;
        if (!sym) begin
            for (int k = 0; k < TAPS; k++) acc += longint'(coef_m[k]) * hist_m[k];
        end else begin
            for (int k = 0; k < TAPS / 2; k++)
                acc += longint'(coef_m[k]) * (hist_m[k] + hist_m[TAPS - 1 - k]);
        end
        acc = acc >>> SHIFT;
        if (acc > 32767)  return 32767;
        if (acc < -32768) return -32768;
        return int'(acc);
    endfunction

    // Write one coefficient while idle.
    task automatic write_coef(input int addr, input int data);
        @(negedge clk);
        while (!ready) @(negedge clk);
        cw_en = 1'b1; cw_addr = 3'(addr); cw_data = 16'(data);
        coef_m[addr] = data;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    // Offer a sample (optionally with a same-cycle write or a busy intrusion),
    // wait for the result and check latency and value.
    task automatic push(input int s, input bit sym, input bit chk, input bit wr,
                        input int waddr, input int wdata, input bit intrude,
                        input string tag);
        int n, m, exp_v, got;
        @(negedge clk);
        while (!ready) @(negedge clk);
        in_valid = 1'b1; in_sample = 16'(s); sym_mode = sym;
        if (wr) begin
            cw_en = 1'b1; cw_addr = 3'(waddr); cw_data = 16'(wdata);
            coef_m[waddr] = wdata;
        end
        @(negedge clk);
        in_valid = 1'b0; cw_en = 1'b0;
        for (int k = TAPS - 1; k > 0; k--) hist_m[k] = hist_m[k - 1];
        hist_m[0] = s;
        exp_v = model(sym);
        m = sym ? TAPS / 2 : TAPS;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (intrude && n == 2) begin
                check(ready == 1'b0, "R5 ready low during sweep", int'(ready), 0);
                in_valid = 1'b1; in_sample = 16'(-7777);
                cw_en = 1'b1; cw_addr = 3'd1; cw_data = 16'(-5000);
            end
            if (intrude && n == 4) begin
                in_valid = 1'b0; cw_en = 1'b0;
            end
        end while (!out_valid && n < 64);
        if (chk) begin
            check(n == m + 3, {tag, " R4 latency"}, n, m + 3);
            got = $signed(out_sample);
            check(got == exp_v, {tag, " R10 value"}, got, exp_v);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 50000);
        n_total++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; sym_mode = 1'b0; cw_en = 1'b0;
        in_sample = '0; cw_data = '0; cw_addr = '0;
        for (int k = 0; k < TAPS; k++) begin hist_m[k] = 0; coef_m[k] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(out_sample == '0, "R1 out_sample", int'(out_sample), 0);
        check(ready == 1'b1, "R1 ready", int'(ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1 && out_valid == 1'b0, "R1 first cycle idle",
              int'({ready, out_valid}), 2);

        // Load coefficients, then flush the history with zeros.
        for (int k = 0; k < TAPS; k++) write_coef(k, INIT_C[k]);
        for (int k = 0; k < TAPS; k++) push(0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, "prime");

        // Table walk: R2 normal, R3 symmetric, R8 history, R9 cleared accumulator.
        for (int i = 0; i < 12; i++) begin
            push(int'($signed(VEC[i][15:0])), VEC[i][16], 1'b1, 1'b0, 0, 0, 1'b0,
                 VEC[i][16] ? "R3 R8 R9 table" : "R2 R8 R9 table");
        end

        // R5: sample and coefficient write offered mid-sweep are dropped.
        push(500, 1'b0, 1'b1, 1'b0, 0, 0, 1'b1, "R5 busy intrusion");
        push(-300, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R5 R8 after intrusion");

        // R6: write and sample in the same idle cycle.
        push(1234, 1'b0, 1'b1, 1'b1, 0, 777, 1'b0, "R6 coincident write");
        push(-45, 1'b1, 1'b1, 1'b1, 2, -900, 1'b0, "R6 R3 coincident write sym");

        // R7: clamp both ways with a single large tap.
        for (int k = 0; k < TAPS; k++) write_coef(k, (k == 0) ? 20000 : 0);
        push(30000, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R7 high");
        check($signed(out_sample) == 32767, "R7 clamp high",
              int'($signed(out_sample)), 32767);
        push(-30000, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R7 low");
        check($signed(out_sample) == -32768, "R7 clamp low",
              int'($signed(out_sample)), -32768);
        push(100, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, "R7 R9 in range");

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule